// File: doc/BRIEF.md
# Audio Clock Generator Control Front End

This block is the control side of a multi-output audio clock generator. It turns three shared pins into a settled configuration: a sampling-frequency group, a standard/double rate selection, and six output-clock enables. It also derives the ratio used for the fourth synthesized clock. A mode pin decides how the three shared pins are read.

With the mode pin low, the pins form a three-wire serial port (latch, shift clock, data). A 16-bit word enters MSB first, one bit on each rising shift-clock edge. A rising latch edge then commits the word. The word is dropped if its identifier does not match, if it holds a reserved code, or if fewer than 16 bits arrived since the previous latch. With the mode pin high, the same pins directly select the rate and the group, and all enables are forced on.

All pins are asynchronous to the master clock. They pass through two-flop synchronizers, and edges are detected on the synchronized copies.

Top module: `audclk_ctrl`

## Requirements
- R1: After reset the outputs are group 00 (48 kHz), rate 00 (standard), all six enables 1, and `sck4_x768` 1.
- R2: In serial mode a word is shifted MSB first on shift-clock rises and committed on a latch rise. Field placement: bits 1:0 group, bits 3:2 rate, bits 9:4 enables (bit 4 = `clk_en[0]` … bit 9 = `clk_en[5]`), bits 15:10 identifier.
- R3: A latched word whose bits 15:10 differ from `REG_ID` (default 6'b011101) leaves all outputs unchanged.
- R4: A latched word with group code 11 or a rate code of 10 or 11 leaves all outputs unchanged. Outputs never show group 11 or a rate code with bit 1 set.
- R5: When more than 16 shift edges occur before a latch, only the last 16 bits are used.
- R6: A latch rise with fewer than 16 shift edges since the previous latch rise (or reset) is ignored. Each latch rise restarts the count.
- R7: In parallel mode the group follows {`pin_sclk_fs1`,`pin_sdat_fs0`} (00 48 kHz, 01 44.1 kHz, 10 32 kHz). Code 11 keeps the previous group. The rate is 01 when `pin_lat_sr` is high and 00 when it is low. All enables are 1. Shift and latch activity is ignored in this mode.
- R8: `sck4_x768` is 1 for standard rate (768·fs) and 0 for double rate (384·fs).
- R9: In serial mode, shift-clock and data activity without a latch rise does not change the outputs.
- R10: On return from parallel to serial mode, the outputs keep the last parallel-mode values until a valid word is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hw | input | 1 | 1 = parallel selection, 0 = serial port (asynchronous) |
| pin_lat_sr | input | 1 | Serial latch / parallel rate select |
| pin_sclk_fs1 | input | 1 | Serial shift clock / parallel group select bit 1 |
| pin_sdat_fs0 | input | 1 | Serial data / parallel group select bit 0 |
| grp_code | output | 2 | Sampling-frequency group |
| rate_code | output | 2 | Rate code, 00 standard, 01 double |
| clk_en | output | 6 | Per-output clock enables |
| sck4_x768 | output | 1 | Fourth clock ratio, 1 = 768·fs, 0 = 384·fs |

## Verification
The properties assume that each level on the shared pins lasts several master-clock cycles. Both synchronized edges must be visible, and serial data must already be settled when the synchronized shift-clock rise arrives. The stimulus therefore holds every shift-clock phase and every latch phase for three or four clocks, and changes data only while the shift clock is low. When the mode changes, the stimulus moves the mode pin and the shared pins in the same cycle, so that no latch rise is seen across the switch.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    localparam int WORD_W = 16;
    localparam int GRP_W  = 2;
    localparam int RATE_W = 2;
    localparam int EN_N   = 6;
    localparam int ID_W   = WORD_W - GRP_W - RATE_W - EN_N;

    typedef enum logic [GRP_W-1:0] {
        GRP_48K  = 2'b00,
        GRP_44K1 = 2'b01,
        GRP_32K  = 2'b10,
        GRP_RSVD = 2'b11
    } grp_e;

    typedef enum logic [RATE_W-1:0] {
        RATE_STD  = 2'b00,
        RATE_DBL  = 2'b01,
        RATE_RSV2 = 2'b10,
        RATE_RSV3 = 2'b11
    } rate_e;

    typedef struct packed {
        logic [EN_N-1:0] en;
        rate_e           rate;
        grp_e            grp;
    } cfg_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        cfg_t            cfg;
    } word_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c.en   = '1;
        c.rate = RATE_STD;
        c.grp  = GRP_48K;
        return c;
    endfunction

    function automatic logic cfg_legal(cfg_t c);
        return (c.grp != GRP_RSVD) && (c.rate inside {RATE_STD, RATE_DBL});
    endfunction

endpackage

// File: rtl/audclk_sync.sv
module audclk_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/audclk_shift.sv
module audclk_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sclk,
    input  logic              sdat,
    input  logic              slat,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o,
    output logic              load_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              sclk_d, slat_d;
    logic              sclk_rise, slat_rise;

    assign sclk_rise = en && sclk && !sclk_d;
    assign slat_rise = en && slat && !slat_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            cnt    <= '0;
            sclk_d <= 1'b0;
            slat_d <= 1'b0;
        end else begin
            sclk_d <= sclk;
            slat_d <= slat;
            if (sclk_rise) begin
                sr <= {sr[WORD_W-2:0], sdat};
                if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
            end
            if (slat_rise) cnt <= '0;
        end
    end

    assign word_o = sr;
    assign full_o = (cnt == CNT_W'(WORD_W));
    assign load_o = slat_rise;
endmodule

// File: rtl/audclk_cfg.sv
module audclk_cfg
    import audclk_pkg::*;
#(
    parameter logic [ID_W-1:0] REG_ID = 6'b011101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw,
    input  logic              hw_sr,
    input  logic [GRP_W-1:0]  hw_fs,
    input  logic              load,
    input  logic              full,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg_q
);
    word_t w;
    cfg_t  nxt;

    assign w = word_t'(word);

    always_comb begin
        nxt = cfg_q;
        if (hw) begin
            nxt.en   = '1;
            nxt.rate = hw_sr ? RATE_DBL : RATE_STD;
            if (grp_e'(hw_fs) != GRP_RSVD) nxt.grp = grp_e'(hw_fs);
        end else if (load && full && (w.id == REG_ID) && cfg_legal(w.cfg)) begin
            nxt = w.cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_default();
        else     cfg_q <= nxt;
    end
endmodule

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
    import audclk_pkg::*;
#(
    parameter logic [ID_W-1:0] REG_ID      = 6'b011101,
    parameter int              SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_hw,
    input  logic             pin_lat_sr,
    input  logic             pin_sclk_fs1,
    input  logic             pin_sdat_fs0,
    output logic [GRP_W-1:0] grp_code,
    output logic [RATE_W-1:0] rate_code,
    output logic [EN_N-1:0]  clk_en,
    output logic             sck4_x768
);
    logic [3:0]        pins_s;
    logic              hw_s, lat_s, sclk_s, sdat_s;
    logic [WORD_W-1:0] sh_word;
    logic              sh_full, ld_pulse;
    cfg_t              cfg;

    audclk_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mode_hw, pin_lat_sr, pin_sclk_fs1, pin_sdat_fs0}),
        .q   (pins_s)
    );

    assign {hw_s, lat_s, sclk_s, sdat_s} = pins_s;

    audclk_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (!hw_s),
        .sclk   (sclk_s),
        .sdat   (sdat_s),
        .slat   (lat_s),
        .word_o (sh_word),
        .full_o (sh_full),
        .load_o (ld_pulse)
    );

    audclk_cfg #(.REG_ID(REG_ID)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .hw    (hw_s),
        .hw_sr (lat_s),
        .hw_fs ({sclk_s, sdat_s}),
        .load  (ld_pulse),
        .full  (sh_full),
        .word  (sh_word),
        .cfg_q (cfg)
    );

    assign grp_code  = cfg.grp;
    assign rate_code = cfg.rate;
    assign clk_en    = cfg.en;
    assign sck4_x768 = (cfg.rate == RATE_STD);
endmodule

// File: rtl/audclk_ctrl_chk.sv
module audclk_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       hw,
    input logic       load,
    input logic [1:0] grp,
    input logic [1:0] rate,
    input logic [5:0] en
);
    assert_grp_legal_R4: assert property (@(posedge clk) disable iff (rst)
        grp != 2'b11);

    assert_rate_legal_R4: assert property (@(posedge clk) disable iff (rst)
        rate[1] == 1'b0);

    assert_hw_enables_R7: assert property (@(posedge clk) disable iff (rst)
        hw |=> (en == 6'h3f));

    assert_hold_no_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (!hw && !load) |=> $stable({grp, rate, en}));
endmodule

bind audclk_ctrl audclk_ctrl_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .hw   (hw_s),
    .load (ld_pulse),
    .grp  (grp_code),
    .rate (rate_code),
    .en   (clk_en)
);

// File: tb/audclk_ctrl_test.sv
module audclk_ctrl_test;
    localparam logic [5:0] ID = 6'b011101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_hw = 1'b0, pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0;
    logic [1:0] grp_code, rate_code;
    logic [5:0] clk_en;
    logic       sck4_x768;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] grp;
        logic [1:0] rate;
        logic [5:0] en;
        logic       x768;
        string      tag;
    } exp_t;
    exp_t q[$];

    logic [1:0]  m_grp = 2'b00, m_rate = 2'b00;
    logic [5:0]  m_en = 6'h3f;
    logic [15:0] m_sr = '0;
    int          m_cnt = 0;

    always #10 clk = ~clk;

    audclk_ctrl uut (
        .clk(clk), .rst(rst), .mode_hw(mode_hw),
        .pin_lat_sr(pin_a), .pin_sclk_fs1(pin_b), .pin_sdat_fs0(pin_c),
        .grp_code(grp_code), .rate_code(rate_code),
        .clk_en(clk_en), .sck4_x768(sck4_x768)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        wait_n(6);
        e.grp = m_grp; e.rate = m_rate; e.en = m_en;
        e.x768 = (m_rate == 2'b00);
        e.tag = tag;
        q.push_back(e);
        wait_n(2);
    endtask

    task automatic send(input logic [31:0] v, input int n, input bit latch);
        for (int i = n - 1; i >= 0; i--) begin
            pin_c = v[i];
            wait_n(3);
            pin_b = 1'b1;
            wait_n(3);
            pin_b = 1'b0;
            m_sr = {m_sr[14:0], v[i]};
            if (m_cnt < 16) m_cnt++;
        end
        if (latch) begin
            wait_n(3);
            pin_a = 1'b1;
            wait_n(4);
            pin_a = 1'b0;
            if (m_cnt == 16 && m_sr[15:10] == ID && m_sr[1:0] != 2'b11 && m_sr[3] == 1'b0) begin
                m_grp = m_sr[1:0]; m_rate = m_sr[3:2]; m_en = m_sr[9:4];
            end
            m_cnt = 0;
        end
    endtask

    task automatic hw_set(input bit md, input bit sr, input logic [1:0] fs);
        mode_hw = md; pin_a = sr; pin_b = fs[1]; pin_c = fs[0];
        if (md) begin
            m_en = 6'h3f;
            m_rate = sr ? 2'b01 : 2'b00;
            if (fs != 2'b11) m_grp = fs;
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (grp_code !== e.grp || rate_code !== e.rate || clk_en !== e.en || sck4_x768 !== e.x768) begin
                failures++;
                $display("FAIL %s got grp=%b rate=%b en=%h x768=%b exp grp=%b rate=%b en=%h x768=%b",
                         e.tag, grp_code, rate_code, clk_en, sck4_x768, e.grp, e.rate, e.en, e.x768);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        push_exp("R1 reset defaults");

        send({16'h0, ID, 6'b101010, 2'b01, 2'b01}, 16, 1'b1);
        push_exp("R2 R8 valid word double rate");

        send({16'h0, 6'b011100, 6'b111111, 2'b00, 2'b10}, 16, 1'b1);
        push_exp("R3 wrong identifier");

        send({16'h0, ID, 6'b111111, 2'b00, 2'b11}, 16, 1'b1);
        push_exp("R4 reserved group");

        send({16'h0, ID, 6'b111111, 2'b10, 2'b00}, 16, 1'b1);
        push_exp("R4 reserved rate");

        send({12'h0, 4'b1011, ID, 6'b000111, 2'b00, 2'b10}, 20, 1'b1);
        push_exp("R5 twenty bits keep last sixteen");

        send({16'h0, ID, 6'b111111, 2'b01, 2'b00}, 12, 1'b1);
        push_exp("R6 short word ignored");

        send({16'h0, ID, 6'b110011, 2'b01, 2'b00}, 16, 1'b0);
        push_exp("R9 shifting without latch");
        send(32'h0, 0, 1'b1);
        push_exp("R2 late latch commits word");

        hw_set(1'b1, 1'b1, 2'b10);
        push_exp("R7 R8 parallel 32k double");
        hw_set(1'b1, 1'b0, 2'b11);
        push_exp("R7 reserved group holds");
        hw_set(1'b1, 1'b1, 2'b01);
        push_exp("R7 parallel 44.1k double");

        hw_set(1'b0, 1'b0, 2'b00);
        push_exp("R10 values kept after leaving parallel");
        send(32'h0, 0, 1'b1);
        push_exp("R6 R7 latch after parallel toggles ignored");

        send({16'h0, ID, 6'b011110, 2'b00, 2'b10}, 16, 1'b1);
        push_exp("R2 R8 serial word after mode return");

        wait (q.size() == 0);
        wait_n(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule